// File: doc/BRIEF.md
# Vector Operand Address Generator

This block turns one memory-to-memory vector instruction into a stream of element addresses. On a start strobe it decodes the instruction's operand-select fields and takes a snapshot of the two 8-bit auxiliary pointers, the filter-bank base and the external-bank base. From the next cycle it issues one complete address set per cycle, one address for each bank, until the requested number of elements has been covered.

Each of the four pointer banks has a 2-bit form code that builds its pointer from its base and the auxiliary pointers. The running element index is added to that pointer. Separate fields send source A, source B and the destination to named banks. The block raises a one-cycle done pulse after the last element. It flags a source-A encoding that is not defined and issues nothing for that instruction. The arithmetic datapath and the memories sit outside this block and consume its outputs.

Top module: `vag_addr_gen`

## Requirements
- R1: While reset is held and right after it, `elem_valid`, `done` and `illegal` are low, and every address and bank-select output is zero.
- R2: A `start` is accepted only when the block is idle and `instr[18:16]` is 3'b011. A `start` with any other value there produces no valid element, no done and no illegal flag.
- R3: The filter address form is chosen by `instr[13:12]` and the external address form by `instr[11:10]`. For each: 0 gives base, 1 gives base+aux0, 2 gives base+aux1, 3 gives base−aux0.
- R4: The RAM0 pointer form is chosen by `instr[9:8]` and the RAM1 pointer form by `instr[7:6]`. For each: 0 gives aux0, 1 gives aux1, 2 gives aux0+aux1, 3 gives aux1−aux0. The auxiliary values are zero-extended.
- R5: Element k adds k to every pointer, and `win_addr` equals k. All addresses wrap modulo 2^ADDR_W, which is 512 by default.
- R6: The bank-select outputs use the codes RAM0=0, RAM1=1, EXT=2, WIN=3, FIL=4, R3=5. Destination `instr[5:4]` maps 0/1/2/3 to RAM0/RAM1/EXT/R3. Source A `instr[3:2]` maps 0/1/2 to RAM0/RAM1/EXT. Source B `instr[1:0]` maps 0/1/2/3 to RAM0/RAM1/WIN/FIL.
- R7: An accepted start yields `elem_valid` for exactly `len_m1`+1 consecutive cycles. The first of these is the cycle after the start edge, with k=0. Up to 512 elements are supported.
- R8: `done` is high for exactly one cycle, the cycle right after the last element, and `elem_valid` is low in that cycle.
- R9: A vector-mode start with `instr[3:2]`=3 raises `illegal` for the one following cycle and issues no element and no done.
- R10: Changes to `instr`, the pointers, the bases or `start` while elements are being issued do not affect the running sequence. No new sequence follows it.
- R11: Whenever `elem_valid` is low, all address outputs and bank-select outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| instr | input | 24 | Vector instruction word |
| aux0 | input | 8 | Auxiliary pointer 0 |
| aux1 | input | 8 | Auxiliary pointer 1 |
| fil_base | input | ADDR_W | Filter bank base |
| ext_base | input | ADDR_W | External bank base |
| len_m1 | input | CNT_W | Element count minus one |
| fil_addr | output | ADDR_W | Filter bank address |
| ext_addr | output | ADDR_W | External bank address |
| ram0_addr | output | ADDR_W | RAM0 address |
| ram1_addr | output | ADDR_W | RAM1 address |
| win_addr | output | ADDR_W | Window bank address (element index) |
| dst_bank | output | 3 | Destination bank code |
| src_a_bank | output | 3 | Source A bank code |
| src_b_bank | output | 3 | Source B bank code |
| elem_valid | output | 1 | Address set valid this cycle |
| done | output | 1 | One-cycle pulse after the last element |
| illegal | output | 1 | Reserved source-A encoding seen |

## Verification
Element k of an accepted instruction is due k+1 cycles after the clock edge that samples `start`. `done` is due len_m1+2 cycles after that edge, and `illegal` is due one cycle after it. The bench drives inputs on the falling edge and then waits a whole number of falling edges before it samples. Each sample therefore lands mid-cycle, in exactly the cycle the requirement names. The bench derives each expected address from the row's element-0 value plus k, taken modulo 512.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [2:0] {
    BK_RAM0 = 3'd0,
    BK_RAM1 = 3'd1,
    BK_EXT  = 3'd2,
    BK_WIN  = 3'd3,
    BK_FIL  = 3'd4,
    BK_REG  = 3'd5
  } bank_e;

  typedef struct packed {
    logic [1:0] fil_form;
    logic [1:0] ext_form;
    logic [1:0] r0_form;
    logic [1:0] r1_form;
    bank_e      dst;
    bank_e      src_a;
    bank_e      src_b;
  } vdec_t;

  localparam logic [2:0] VEC_CLASS = 3'b011;
  localparam int         NUM_PTR   = 4;

endpackage

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
(
  input  logic [23:0] instr,
  output logic        is_vec,
  output logic        src_a_bad,
  output vdec_t       dec
);

  always_comb begin
    is_vec       = (instr[18:16] == VEC_CLASS);
    dec.fil_form = instr[13:12];
    dec.ext_form = instr[11:10];
    dec.r0_form  = instr[9:8];
    dec.r1_form  = instr[7:6];

    case (instr[5:4])
      2'd0:    dec.dst = BK_RAM0;
      2'd1:    dec.dst = BK_RAM1;
      2'd2:    dec.dst = BK_EXT;
      default: dec.dst = BK_REG;
    endcase

    src_a_bad = 1'b0;
    case (instr[3:2])
      2'd0: dec.src_a = BK_RAM0;
      2'd1: dec.src_a = BK_RAM1;
      2'd2: dec.src_a = BK_EXT;
      default: begin
        dec.src_a = BK_RAM0;
        src_a_bad = 1'b1;
      end
    endcase

    case (instr[1:0])
      2'd0:    dec.src_b = BK_RAM0;
      2'd1:    dec.src_b = BK_RAM1;
      2'd2:    dec.src_b = BK_WIN;
      default: dec.src_b = BK_FIL;
    endcase
  end

  logic [7:0] unused_op;
  assign unused_op = {instr[23:19], instr[15:14], 1'b0};

endmodule

// File: rtl/vag_ptr.sv
module vag_ptr #(
  parameter int ADDR_W = 9,
  parameter int AUX_W  = 8,
  parameter bit BASED  = 1'b1
) (
  input  logic [1:0]        form,
  input  logic [ADDR_W-1:0] base,
  input  logic [AUX_W-1:0]  aux0,
  input  logic [AUX_W-1:0]  aux1,
  input  logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] a0, a1, off;

  assign a0 = ADDR_W'(aux0);
  assign a1 = ADDR_W'(aux1);

  generate
    if (BASED) begin : g_based
      always_comb begin
        case (form)
          2'd0:    off = base;
          2'd1:    off = base + a0;
          2'd2:    off = base + a1;
          default: off = base - a0;
        endcase
      end
    end else begin : g_aux
      logic unused_base;
      assign unused_base = ^base;
      always_comb begin
        case (form)
          2'd0:    off = a0;
          2'd1:    off = a1;
          2'd2:    off = a0 + a1;
          default: off = a1 - a0;
        endcase
      end
    end
  endgenerate

  assign addr = off + idx;

endmodule

// File: rtl/vag_seq.sv
module vag_seq #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             reject,
  input  logic [CNT_W-1:0] last_idx,
  output logic             busy,
  output logic [CNT_W-1:0] idx,
  output logic             done,
  output logic             illegal
);

  logic             busy_n, done_n, ill_n;
  logic [CNT_W-1:0] idx_n;

  always_comb begin
    busy_n = busy;
    idx_n  = idx;
    done_n = 1'b0;
    ill_n  = reject;
    if (accept) begin
      busy_n = 1'b1;
      idx_n  = '0;
    end else if (busy) begin
      if (idx == last_idx) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        idx_n  = '0;
      end else begin
        idx_n = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      busy    <= busy_n;
      idx     <= idx_n;
      done    <= done_n;
      illegal <= ill_n;
    end
  end

endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int AUX_W    = 8,
  parameter int MAX_ELEM = 512,
  parameter int CNT_W    = $clog2(MAX_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       instr,
  input  logic [AUX_W-1:0]  aux0,
  input  logic [AUX_W-1:0]  aux1,
  input  logic [ADDR_W-1:0] fil_base,
  input  logic [ADDR_W-1:0] ext_base,
  input  logic [CNT_W-1:0]  len_m1,
  output logic [ADDR_W-1:0] fil_addr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] ram0_addr,
  output logic [ADDR_W-1:0] ram1_addr,
  output logic [ADDR_W-1:0] win_addr,
  output logic [2:0]        dst_bank,
  output logic [2:0]        src_a_bank,
  output logic [2:0]        src_b_bank,
  output logic              elem_valid,
  output logic              done,
  output logic              illegal
);

  logic        is_vec, src_a_bad;
  vdec_t       dec, dec_q;
  logic        busy, accept, reject;
  logic [CNT_W-1:0]  idx, last_q;
  logic [AUX_W-1:0]  aux0_q, aux1_q;
  logic [ADDR_W-1:0] fb_q, eb_q, idx_a;

  vag_decode u_dec (
    .instr     (instr),
    .is_vec    (is_vec),
    .src_a_bad (src_a_bad),
    .dec       (dec)
  );

  assign accept = start & ~busy & is_vec & ~src_a_bad;
  assign reject = start & ~busy & is_vec &  src_a_bad;

  // operand snapshot, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      aux0_q <= '0;
      aux1_q <= '0;
      fb_q   <= '0;
      eb_q   <= '0;
      last_q <= '0;
    end else if (accept) begin
      dec_q  <= dec;
      aux0_q <= aux0;
      aux1_q <= aux1;
      fb_q   <= fil_base;
      eb_q   <= ext_base;
      last_q <= len_m1;
    end
  end

  vag_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .reject   (reject),
    .last_idx (last_q),
    .busy     (busy),
    .idx      (idx),
    .done     (done),
    .illegal  (illegal)
  );

  assign idx_a = ADDR_W'(idx);

  logic [1:0]        form_arr [NUM_PTR];
  logic [ADDR_W-1:0] base_arr [NUM_PTR];
  logic [ADDR_W-1:0] addr_arr [NUM_PTR];

  assign form_arr[0] = dec_q.fil_form;
  assign form_arr[1] = dec_q.ext_form;
  assign form_arr[2] = dec_q.r0_form;
  assign form_arr[3] = dec_q.r1_form;
  assign base_arr[0] = fb_q;
  assign base_arr[1] = eb_q;
  assign base_arr[2] = '0;
  assign base_arr[3] = '0;

  generate
    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
      vag_ptr #(
        .ADDR_W (ADDR_W),
        .AUX_W  (AUX_W),
        .BASED  (gi < 2)
      ) u_ptr (
        .form (form_arr[gi]),
        .base (base_arr[gi]),
        .aux0 (aux0_q),
        .aux1 (aux1_q),
        .idx  (idx_a),
        .addr (addr_arr[gi])
      );
    end
  endgenerate

  assign elem_valid = busy;
  assign fil_addr   = busy ? addr_arr[0] : '0;
  assign ext_addr   = busy ? addr_arr[1] : '0;
  assign ram0_addr  = busy ? addr_arr[2] : '0;
  assign ram1_addr  = busy ? addr_arr[3] : '0;
  assign win_addr   = busy ? idx_a       : '0;
  assign dst_bank   = busy ? dec_q.dst   : BK_RAM0;
  assign src_a_bank = busy ? dec_q.src_a : BK_RAM0;
  assign src_b_bank = busy ? dec_q.src_b : BK_RAM0;

endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [23:0]       instr,
  input logic [ADDR_W-1:0] fil_addr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] ram0_addr,
  input logic [ADDR_W-1:0] ram1_addr,
  input logic [ADDR_W-1:0] win_addr,
  input logic [2:0]        dst_bank,
  input logic              elem_valid,
  input logic              done,
  input logic              illegal
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!elem_valid && $past(elem_valid)));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!elem_valid && !done));

  // R7
  first_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(elem_valid) |-> (win_addr == '0));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(elem_valid) |-> ($past(start) && ($past(instr[18:16]) == 3'b011)));

  // R5
  ram0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && $past(elem_valid)) |->
      (ram0_addr == ADDR_W'($past(ram0_addr) + 1'b1)));

  // R5
  fil_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && $past(elem_valid)) |->
      (fil_addr == ADDR_W'($past(fil_addr) + 1'b1)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !elem_valid |-> (fil_addr == '0 && ext_addr == '0 && ram0_addr == '0 &&
                     ram1_addr == '0 && win_addr == '0 && dst_bank == '0));

endmodule

bind vag_addr_gen vag_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .instr      (instr),
  .fil_addr   (fil_addr),
  .ext_addr   (ext_addr),
  .ram0_addr  (ram0_addr),
  .ram1_addr  (ram1_addr),
  .win_addr   (win_addr),
  .dst_bank   (dst_bank),
  .elem_valid (elem_valid),
  .done       (done),
  .illegal    (illegal)
);

// File: tb/sim_vag_addr_gen.sv
`timescale 1ns/1ps
module sim_vag_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] instr;
  logic [7:0]  aux0, aux1;
  logic [8:0]  fil_base, ext_base, len_m1;
  logic [8:0]  fil_addr, ext_addr, ram0_addr, ram1_addr, win_addr;
  logic [2:0]  dst_bank, src_a_bank, src_b_bank;
  logic        elem_valid, done, illegal;

  int nchk  = 0;
  int nfail = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  vag_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .aux0(aux0), .aux1(aux1), .fil_base(fil_base), .ext_base(ext_base),
    .len_m1(len_m1), .fil_addr(fil_addr), .ext_addr(ext_addr),
    .ram0_addr(ram0_addr), .ram1_addr(ram1_addr), .win_addr(win_addr),
    .dst_bank(dst_bank), .src_a_bank(src_a_bank), .src_b_bank(src_b_bank),
    .elem_valid(elem_valid), .done(done), .illegal(illegal)
  );

  typedef struct packed {
    logic [1:0] fm, em, r0m, r1m, dm, am, bm;
    logic [7:0] a0, a1;
    logic [8:0] fb, eb, xf, xe, x0, x1;
    logic [2:0] xd, xa, xb;
  } row_t;

  localparam row_t TBL [4] = '{
    '{2'd0,2'd1,2'd0,2'd1,2'd0,2'd0,2'd0, 8'd10, 8'd20, 9'd100,9'd200, 9'd100,9'd210,9'd10, 9'd20,  3'd0,3'd0,3'd0},
    '{2'd1,2'd2,2'd2,2'd3,2'd1,2'd1,2'd1, 8'd5,  8'd3,  9'd500,9'd7,   9'd505,9'd10, 9'd8,  9'd510, 3'd1,3'd1,3'd1},
    '{2'd2,2'd3,2'd1,2'd0,2'd2,2'd2,2'd2, 8'd255,8'd255,9'd511,9'd0,   9'd254,9'd257,9'd255,9'd255, 3'd2,3'd2,3'd3},
    '{2'd3,2'd0,2'd3,2'd2,2'd3,2'd1,2'd3, 8'd1,  8'd0,  9'd0,  9'd300, 9'd511,9'd300,9'd511,9'd1,   3'd5,3'd1,3'd4}
  };

  function automatic logic [23:0] mk(input logic [1:0] fm, em, r0m, r1m, dm, am, bm);
    return {5'h0A, 3'b011, 2'b00, fm, em, r0m, r1m, dm, am, bm};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // drive at a falling edge; returns at the falling edge where element 0 is shown
  task automatic launch(input logic [23:0] ins, input logic [7:0] p0, p1,
                        input logic [8:0] fb, eb, lm);
    @(negedge clk);
    instr = ins; aux0 = p0; aux1 = p1; fil_base = fb; ext_base = eb;
    len_m1 = lm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; aux0 = '0; aux1 = '0;
    fil_base = '0; ext_base = '0; len_m1 = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!elem_valid && !done && !illegal, "R1 flags in reset", elem_valid, 0);
    chk(fil_addr == 0 && ram0_addr == 0 && dst_bank == 0, "R1 outputs in reset", fil_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!elem_valid && !done && !illegal, "R1 flags after reset", elem_valid, 0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int r = 0; r < 4; r++) begin
      launch(mk(TBL[r].fm, TBL[r].em, TBL[r].r0m, TBL[r].r1m, TBL[r].dm, TBL[r].am, TBL[r].bm),
             TBL[r].a0, TBL[r].a1, TBL[r].fb, TBL[r].eb, 9'd2);
      for (int k = 0; k < 3; k++) begin
        chk(elem_valid == 1'b1, "R7 valid", elem_valid, 1);
        chk(fil_addr  == 9'(TBL[r].xf + k), "R3 fil", fil_addr, 9'(TBL[r].xf + k));
        chk(ext_addr  == 9'(TBL[r].xe + k), "R3 ext", ext_addr, 9'(TBL[r].xe + k));
        chk(ram0_addr == 9'(TBL[r].x0 + k), "R4 ram0", ram0_addr, 9'(TBL[r].x0 + k));
        chk(ram1_addr == 9'(TBL[r].x1 + k), "R4 ram1 R5 wrap", ram1_addr, 9'(TBL[r].x1 + k));
        chk(win_addr  == 9'(k), "R5 win", win_addr, k);
        chk(dst_bank == TBL[r].xd, "R6 dst", dst_bank, TBL[r].xd);
        chk(src_a_bank == TBL[r].xa, "R6 srca", src_a_bank, TBL[r].xa);
        chk(src_b_bank == TBL[r].xb, "R6 srcb", src_b_bank, TBL[r].xb);
        @(negedge clk);
      end
      chk(!elem_valid && done, "R8 done after last", done, 1);
      chk(fil_addr == 0 && src_b_bank == 0, "R11 idle zero", fil_addr, 0);
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
    end

    // R2 non-vector start ignored
    launch({5'h0A, 3'b010, 16'h0000}, 8'd1, 8'd2, 9'd3, 9'd4, 9'd2);
    chk(!elem_valid && !illegal, "R2 non-vector ignored", elem_valid, 0);
    @(negedge clk);
    chk(!elem_valid && !done, "R2 no later activity", done, 0);

    // R9 reserved source A
    launch(mk(2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0), 8'd1, 8'd2, 9'd3, 9'd4, 9'd2);
    chk(illegal && !elem_valid, "R9 illegal raised", illegal, 1);
    @(negedge clk);
    chk(!illegal && !elem_valid, "R9 illegal one cycle", illegal, 0);
    repeat (3) @(negedge clk);
    chk(!elem_valid && !done, "R9 nothing issued", done, 0);

    // R10 snapshot and start during run
    launch(mk(2'd1, 2'd2, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0), 8'd10, 8'd20, 9'd100, 9'd200, 9'd2);
    chk(fil_addr == 9'd110, "R10 first element", fil_addr, 110);
    instr = mk(2'd0, 2'd0, 2'd1, 2'd1, 2'd3, 2'd1, 2'd3);
    aux0 = 8'd99; aux1 = 8'd7; fil_base = 9'd1; ext_base = 9'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fil_addr == 9'd111, "R10 fil kept", fil_addr, 111);
    chk(ext_addr == 9'd221, "R10 ext kept", ext_addr, 221);
    chk(ram0_addr == 9'd11 && ram1_addr == 9'd31, "R10 ram kept", ram0_addr, 11);
    chk(dst_bank == 3'd0, "R10 dst kept", dst_bank, 0);
    @(negedge clk);
    chk(elem_valid && win_addr == 9'd2, "R10 last element", win_addr, 2);
    @(negedge clk);
    chk(done && !elem_valid, "R10 done", done, 1);
    @(negedge clk);
    chk(!elem_valid, "R10 no second run", elem_valid, 0);

    // R7 full 512-element run
    begin
      int cnt = 0;
      launch(mk(2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0), 8'd0, 8'd0, 9'd0, 9'd0, 9'd511);
      while (elem_valid && cnt < 600) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == 512, "R7 512 elements", cnt, 512);
      chk(done, "R8 done after 512", done, 1);
    end

    summary();
  end

endmodule